// File: doc/BRIEF.md
# Two-Step Watchdog Refresh Controller

This block is a watchdog timer whose control sits in two 8-bit special-function registers, one at address 0xA8 and one at 0xB8. Bit 6 of the 0xA8 register is an arm flag. Bit 6 of the 0xB8 register is a start/refresh flag. Both flags clear themselves in hardware. A write that sets the start/refresh flag starts a stopped watchdog. It reloads a running watchdog only when the arm flag is still set at the moment of that write. A start/refresh write on its own therefore cannot keep the watchdog alive.

Once started, the watchdog is a down-counter of `TIMEOUT` cycles. Each time it expires it gives a one-cycle pulse on its reset output and then reloads itself. Software cannot stop it; only the system reset clears it. The other bits of both registers are interrupt enables (bit 7 of 0xA8 being the global enable). The block keeps these only as plain storage. Reads are registered, so read data appears one cycle after the address is presented.

Top module: `wdr_ctrl_top`

## Requirements
- R1: After reset, both registers read 0x00 and `wdg_rst_o` stays low while the watchdog has not been started.
- R2: Writable enable bits read back as written: mask 0x9F at 0xA8 (bits 7, 4..0) and mask 0x3E at 0xB8 (bits 5..1). Bit 5 of 0xA8 and bits 7 and 0 of 0xB8 read 0 whatever is written. Read data for the address sampled at clock edge k is valid after edge k and reflects state before that edge's write.
- R3: A write with bit 6 = 1 to 0xA8 at edge k makes bit 6 of 0xA8 read 1 at edges k+1 through k+12 and 0 from edge k+13.
- R4: A write with bit 6 = 1 to 0xB8 at edge k makes bit 6 of 0xB8 read 1 at edges k+1 through k+12 and 0 from edge k+13.
- R5: A start write (0xB8, bit 6 = 1) at edge s while the watchdog is stopped starts it. `wdg_rst_o` is then high after edges s+T, s+2T, and so on (T = `TIMEOUT`).
- R6: A start write at edge r while the arm bit is set (arm written at edge a, a+1 <= r <= a+12) reloads the watchdog, so the next pulse follows edge r+T.
- R7: A start write while running with the arm bit clear does not change the pulse schedule.
- R8: A start write 13 or more edges after the arm write is not a refresh.
- R9: Writing 0 to either register does not stop a running watchdog.
- R10: Setting a self-clearing bit again while it is set restarts its 12-cycle window from the new write.
- R11: Every `wdg_rst_o` pulse lasts exactly one cycle.
- R12: Writing 0 to bit 6 of either register clears that flag at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr_i | input | 8 | Register address for write and read |
| sfr_wdata_i | input | 8 | Write data |
| sfr_we_i | input | 1 | Write strobe, one cycle per write |
| sfr_rdata_o | output | 8 | Registered read data for the previous cycle's address |
| wdg_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that `TIMEOUT` is at least 2 and that a write strobe is a single-cycle event whose address and data are stable in that cycle. The bench drives every write as a one-cycle strobe at the falling edge. It also spaces the refresh attempts so that none falls on the same edge as a watchdog expiry. The assertions also assume reset is held for at least one edge before any traffic, and the bench keeps all traffic off the bus during reset.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int unsigned DW = 8;
  localparam logic [7:0] ADDR_ARM   = 8'hA8;
  localparam logic [7:0] ADDR_START = 8'hB8;
  localparam int unsigned CTRL_BIT  = 6;
  localparam int unsigned HOLD_CYC  = 12;
  localparam logic [7:0] MASK_EN0   = 8'h9F;
  localparam logic [7:0] MASK_EN1   = 8'h3E;
endpackage

// File: rtl/wdr_selfclr_bit.sv
module wdr_selfclr_bit #(
  parameter int unsigned HOLD = 12,
  localparam int unsigned CW = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      cnt_q  <= '0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      cnt_q  <= CW'(HOLD - 1);
    end else if (clr_i) begin
      flag_o <= 1'b0;
      cnt_q  <= '0;
    end else if (flag_o) begin
      if (cnt_q == '0) flag_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R10: a set always opens a full fresh window
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (flag_o && cnt_q == CW'(HOLD - 1)));
  // R3/R4: window counter never exceeds its length
  a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
    flag_o |-> (cnt_q <= CW'(HOLD - 1)));
  // R12: a clear without a set drops the flag
  a_r12_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/wdr_counter.sv
module wdr_counter #(
  parameter int unsigned TIMEOUT = 64,
  localparam int unsigned CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_wr_i,
  input  logic arm_i,
  output logic wdg_rst_o
);
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          load;

  assign load = start_wr_i && (!run_q || arm_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      wdg_rst_o <= 1'b0;
    end else begin
      wdg_rst_o <= 1'b0;
      if (load) begin
        run_q <= 1'b1;
        cnt_q <= CW'(TIMEOUT - 1);
      end else if (run_q) begin
        if (cnt_q == '0) begin
          wdg_rst_o <= 1'b1;
          cnt_q     <= CW'(TIMEOUT - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R9: once running, only reset stops it
  a_r9_no_stop: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);
  // R11: pulse is a single cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wdg_rst_o |=> !wdg_rst_o);
  // R7: without a qualified load a running count keeps descending
  a_r7_no_reload: assert property (@(posedge clk) disable iff (rst)
    (run_q && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5: expiry produces a pulse
  a_r5_fire: assert property (@(posedge clk) disable iff (rst)
    (run_q && !load && cnt_q == '0) |=> wdg_rst_o);
  // R1: no pulse while stopped
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_wr_i) |=> !wdg_rst_o);
endmodule

// File: rtl/wdr_ctrl_top.sv
module wdr_ctrl_top #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sfr_addr_i,
  input  logic [7:0] sfr_wdata_i,
  input  logic       sfr_we_i,
  output logic [7:0] sfr_rdata_o,
  output logic       wdg_rst_o
);
  import wdr_pkg::*;

  logic       wr_arm_reg, wr_start_reg;
  logic [7:0] en0_q, en1_q;
  logic       arm_flag, start_flag;
  logic       arm_set, arm_clr, start_set, start_clr;
  logic [7:0] rd_mux;

  assign wr_arm_reg   = sfr_we_i && (sfr_addr_i == ADDR_ARM);
  assign wr_start_reg = sfr_we_i && (sfr_addr_i == ADDR_START);
  assign arm_set      = wr_arm_reg   &&  sfr_wdata_i[CTRL_BIT];
  assign arm_clr      = wr_arm_reg   && !sfr_wdata_i[CTRL_BIT];
  assign start_set    = wr_start_reg &&  sfr_wdata_i[CTRL_BIT];
  assign start_clr    = wr_start_reg && !sfr_wdata_i[CTRL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en0_q <= '0;
      en1_q <= '0;
    end else begin
      if (wr_arm_reg)   en0_q <= sfr_wdata_i & MASK_EN0;
      if (wr_start_reg) en1_q <= sfr_wdata_i & MASK_EN1;
    end
  end

  wdr_selfclr_bit #(.HOLD(HOLD_CYC)) u_arm (
    .clk(clk), .rst(rst), .set_i(arm_set), .clr_i(arm_clr), .flag_o(arm_flag)
  );

  wdr_selfclr_bit #(.HOLD(HOLD_CYC)) u_start (
    .clk(clk), .rst(rst), .set_i(start_set), .clr_i(start_clr), .flag_o(start_flag)
  );

  wdr_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk(clk), .rst(rst), .start_wr_i(start_set), .arm_i(arm_flag),
    .wdg_rst_o(wdg_rst_o)
  );

  always_comb begin
    rd_mux = '0;
    if (sfr_addr_i == ADDR_ARM) begin
      rd_mux = en0_q;
      rd_mux[CTRL_BIT] = arm_flag;
    end else if (sfr_addr_i == ADDR_START) begin
      rd_mux = en1_q;
      rd_mux[CTRL_BIT] = start_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sfr_rdata_o <= '0;
    else     sfr_rdata_o <= rd_mux;
  end

  // R2: undefined bits never read as 1
  a_r2_undef_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(sfr_addr_i) == ADDR_START) |-> (sfr_rdata_o[7] == 1'b0 && sfr_rdata_o[0] == 1'b0));
endmodule

// File: tb/wdr_ctrl_top_tb_top.sv
module wdr_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic       wdg_rst;

  wdr_ctrl_top #(.TIMEOUT(T)) dut_i (
    .clk(clk), .rst(rst), .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata),
    .sfr_we_i(sfr_we), .sfr_rdata_o(sfr_rdata), .wdg_rst_o(wdg_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  typedef struct { int edge_n; logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t rd_q[$];

  // reference model of the pulse schedule
  bit run_m = 0;
  int next_fire = 0;
  bit arm_valid = 0;
  int arm_edge = 0;
  bit live = 0;
  string pulse_tag = "R5";

  function automatic bit arm_active(int e);
    return arm_valid && (e >= arm_edge + 1) && (e <= arm_edge + 12);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    int e;
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(posedge clk);
    #1;
    e = cyc;
    sfr_we = 1'b0;
    if (a == 8'hA8) begin
      if (d[6]) begin arm_valid = 1; arm_edge = e; end
      else arm_valid = 0;
    end
    if (a == 8'hB8 && d[6]) begin
      if (!run_m) begin run_m = 1; next_fire = e + T; end
      else if (arm_active(e)) next_fire = e + T;
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] x, input string tag);
    rd_item_t it;
    @(negedge clk);
    sfr_addr = a; sfr_we = 1'b0;
    @(posedge clk);
    #1;
    it.edge_n = cyc; it.exp = x; it.tag = tag;
    rd_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sfr_we = 1'b0;
      @(posedge clk);
      #1;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (live) begin
      bit exp_p;
      exp_p = run_m && (cyc == next_fire);
      if (exp_p) next_fire = next_fire + T;
      checks++;
      if (wdg_rst !== exp_p) begin
        errors++;
        $display("FAIL %s/R11 pulse at edge %0d: actual=%b expected=%b", pulse_tag, cyc, wdg_rst, exp_p);
      end
      if (rd_q.size() > 0 && rd_q[0].edge_n == cyc) begin
        rd_item_t it;
        it = rd_q.pop_front();
        checks++;
        if (sfr_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s read at edge %0d: actual=%h expected=%h", it.tag, cyc, sfr_rdata, it.exp);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    live = 1;
    // R1 reset state
    rd(8'hA8, 8'h00, "R1");
    rd(8'hB8, 8'h00, "R1");
    idle(20);
    // R2 storage and undefined bits
    wr(8'hA8, 8'hA5); rd(8'hA8, 8'h85, "R2");
    wr(8'hB8, 8'h95); rd(8'hB8, 8'h14, "R2");
    wr(8'hB8, 8'h2A); rd(8'hB8, 8'h2A, "R2");
    wr(8'hA8, 8'h1F); rd(8'hA8, 8'h1F, "R2");
    rd(8'h00, 8'h00, "R2");
    // R3 arm window
    wr(8'hA8, 8'h40);
    for (int k = 1; k <= 14; k++) rd(8'hA8, (k <= 12) ? 8'h40 : 8'h00, "R3");
    // R12 immediate clear
    wr(8'hA8, 8'h40); wr(8'hA8, 8'h00); rd(8'hA8, 8'h00, "R12");
    // R4 + R5 start
    wr(8'hB8, 8'h40);
    for (int k = 1; k <= 14; k++) rd(8'hB8, (k <= 12) ? 8'h40 : 8'h00, "R4");
    idle(2*T);
    // R6 refresh inside window, last legal edge
    pulse_tag = "R6";
    wr(8'hA8, 8'h40); idle(3); wr(8'hB8, 8'h40); idle(T/2);
    wr(8'hA8, 8'h40); idle(11); wr(8'hB8, 8'h40); idle(T + 5);
    // R7 start alone
    pulse_tag = "R7";
    idle(10); wr(8'hB8, 8'h40); idle(T);
    // R8 outside window
    pulse_tag = "R8";
    wr(8'hA8, 8'h40); idle(12); wr(8'hB8, 8'h40); idle(T);
    // R10 restart of arm window
    pulse_tag = "R10";
    wr(8'hA8, 8'h40); e0 = cyc; idle(8); wr(8'hA8, 8'h40);
    for (int k = 1; k <= 13; k++) rd(8'hA8, (k <= 12) ? 8'h40 : 8'h00, "R10");
    wr(8'hA8, 8'h40); idle(10); wr(8'hB8, 8'h40); idle(T);
    if (e0 < 0) $display("unexpected");
    // R9 zero writes do not stop
    pulse_tag = "R9";
    wr(8'hA8, 8'h00); wr(8'hB8, 8'h00); idle(3*T);
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule